// File: doc/BRIEF.md
# I2C SCL Period Generator

This block sets the timing of the clock line for an I2C master. It keeps a high count and a low count for standard mode and another pair for fast mode. A select input picks the pair. From that pair it times three intervals, all in core clock cycles: the hold after a START condition, the SCL low phase and the SCL high phase. It asks the pad logic to pull SCL low by raising a drive-low request. It reads the sampled SCL line back so that a slave holding the line low stretches the high phase.

When the block is enabled it first holds SCL released for the post-START hold. It then alternates low and high phases until it is disabled. A byte-level engine, which is outside this block, uses two single-cycle strobes to shift SDA data: one at the falling edge and one at the rising edge. The count inputs and the select are captured only while the block is disabled, so software may rewrite them at any time without tearing a phase in progress. The block has no streaming data path. All pins are plain control and status signals, and there is no handshake or back-pressure.

Top module: `scl_period_gen`

## Requirements
- R1: With `fast_sel` = 1 the fast pair (`fast_hcnt`, `fast_lcnt`) sets the timing. With `fast_sel` = 0 the standard pair (`std_hcnt`, `std_lcnt`) sets it. The other pair has no effect.
- R2: After `en` rises, SCL stays released for HCNT + 3 cycles before the first cycle in which `scl_drive_low` is 1.
- R3: Each low phase asserts `scl_drive_low` for exactly LCNT + 1 consecutive cycles. Counting starts in the first cycle of the drive-low request.
- R4: With no clock stretching, each high phase keeps `scl_drive_low` at 0 for exactly HCNT + 8 cycles between two low phases.
- R5: During a high phase, a cycle in which `scl_in` is sampled 0 is not counted, and the high phase cannot end in such a cycle. A stretch of S cycles therefore lengthens the released time to S + HCNT + 8.
- R6: The selected counts are captured on each clock edge at which `en` is 0. A change to the count inputs or to `fast_sel` made while `en` is 1 has no effect until the next enable. This includes a change made in the same cycle that `en` rises.
- R7: One edge after `en` is sampled 0, `scl_drive_low`, `scl_rise_stb` and `scl_fall_stb` are 0 and all counters are reset. The next enable starts again with the full post-START hold.
- R8: `scl_fall_stb` is 1 only in the first cycle of each low phase. `scl_rise_stb` is 1 only in the first cycle of a high phase in which `scl_in` is 1. Each strobe fires once per phase, and the two never fire in the same cycle.
- R9: While `rst_n` is 0, `scl_drive_low`, `scl_rise_stb` and `scl_fall_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; 0 releases SCL and clears all counters |
| fast_sel | input | 1 | 1 selects the fast-mode count pair, 0 the standard pair |
| std_hcnt | input | CNT_W | Standard-mode high count |
| std_lcnt | input | CNT_W | Standard-mode low count |
| fast_hcnt | input | CNT_W | Fast-mode high count |
| fast_lcnt | input | CNT_W | Fast-mode low count |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| scl_rise_stb | output | 1 | One-cycle strobe at the observed SCL rising edge |
| scl_fall_stb | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
Two functions can fall in the same cycle: capture of the count registers, and the rising edge of `en` that freezes them. The bench rewrites the high count in the very cycle that `en` goes to 1. It then expects the hold and high lengths that the earlier value gives, not the new one. A second collision is the end of a clock stretch with the first counted high cycle. The bench releases the line after a chosen number of stretched samples. It expects the rise strobe exactly on the next sample, and a released time of the stretch plus HCNT + 8.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  localparam int HOLD_EXTRA = 3;
  localparam int LOW_EXTRA  = 1;
  localparam int HIGH_EXTRA = 8;

endpackage

// File: rtl/scl_cfg_sel.sv
module scl_cfg_sel #(
  parameter int CNT_W = 16,
  localparam int TW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] std_hcnt,
  input  logic [CNT_W-1:0] std_lcnt,
  input  logic [CNT_W-1:0] fast_hcnt,
  input  logic [CNT_W-1:0] fast_lcnt,
  output logic [TW-1:0]    term_hold,
  output logic [TW-1:0]    term_low,
  output logic [TW-1:0]    term_high
);
  import scl_timing_pkg::*;

  logic [CNT_W-1:0] hi_q, lo_q;

  // Only the chosen pair is kept; capture happens while disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (!en) begin
      hi_q <= fast_sel ? fast_hcnt : std_hcnt;
      lo_q <= fast_sel ? fast_lcnt : std_lcnt;
    end
  end

  // Terminal value = phase length - 1.
  assign term_hold = TW'(hi_q) + TW'(HOLD_EXTRA - 1);
  assign term_low  = TW'(lo_q) + TW'(LOW_EXTRA - 1);
  assign term_high = TW'(hi_q) + TW'(HIGH_EXTRA - 1);

  // R6: captured counts do not move while running
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int TW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [TW-1:0] term,
  output logic [TW-1:0] cnt,
  output logic          at_term
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + TW'(1);
  end

  assign at_term = adv && (cnt == term);

  // R4: a running count never passes its phase terminal
  a_r4_within_term: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt <= term));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W = 16,
  localparam int TW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] std_hcnt,
  input  logic [CNT_W-1:0] std_lcnt,
  input  logic [CNT_W-1:0] fast_hcnt,
  input  logic [CNT_W-1:0] fast_lcnt,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             scl_rise_stb,
  output logic             scl_fall_stb
);
  import scl_timing_pkg::*;

  scl_phase_e     phase_q, phase_d;
  logic           seen_q, seen_d;
  logic [TW-1:0]  t_hold, t_low, t_high, term;
  logic [TW-1:0]  cnt;
  logic           adv, clr, at_term;

  scl_cfg_sel #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .fast_sel  (fast_sel),
    .std_hcnt  (std_hcnt),
    .std_lcnt  (std_lcnt),
    .fast_hcnt (fast_hcnt),
    .fast_lcnt (fast_lcnt),
    .term_hold (t_hold),
    .term_low  (t_low),
    .term_high (t_high)
  );

  always_comb begin
    unique case (phase_q)
      PH_HOLD: term = t_hold;
      PH_LOW:  term = t_low;
      PH_HIGH: term = t_high;
      default: term = '0;
    endcase
  end

  // High phase only counts while the line is really high (stretching).
  assign adv = (phase_q == PH_HOLD) || (phase_q == PH_LOW) ||
               ((phase_q == PH_HIGH) && scl_in);
  assign clr = !en || (phase_q == PH_IDLE) || at_term;

  scl_phase_ctr #(.TW(TW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .adv     (adv),
    .term    (term),
    .cnt     (cnt),
    .at_term (at_term)
  );

  always_comb begin
    phase_d = phase_q;
    if (!en) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_HOLD;
        PH_HOLD: if (at_term) phase_d = PH_LOW;
        PH_LOW:  if (at_term) phase_d = PH_HIGH;
        PH_HIGH: if (at_term) phase_d = PH_LOW;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  assign seen_d = en && (phase_q == PH_HIGH) && !at_term && (seen_q || scl_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      seen_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      seen_q  <= seen_d;
    end
  end

  assign scl_drive_low = (phase_q == PH_LOW);
  assign scl_fall_stb  = (phase_q == PH_LOW) && (cnt == '0);
  assign scl_rise_stb  = (phase_q == PH_HIGH) && scl_in && !seen_q;

  // R7: one edge after disable SCL is released and strobes are quiet
  a_r7_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !scl_rise_stb && !scl_fall_stb));

  // R5: a high phase cannot end while the line is held low
  a_r5_no_end_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase_q == PH_HIGH && !scl_in) |=> (phase_q == PH_HIGH));

  // R8: the two strobes never coincide
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise_stb && scl_fall_stb));

  // R3: every new low phase opens with the fall strobe
  a_r3_fall_on_rose: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> scl_fall_stb);

endmodule

// File: tb/sim_scl_period_gen.sv
module sim_scl_period_gen;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fast_sel = 1'b0;
  logic stretch = 1'b0;
  logic [CW-1:0] s_h = '0, s_l = '0, f_h = '0, f_l = '0;
  logic drv, rise, fall, scl_line;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign scl_line = !drv && !stretch;

  scl_period_gen #(.CNT_W(CW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .fast_sel      (fast_sel),
    .std_hcnt      (s_h),
    .std_lcnt      (s_l),
    .fast_hcnt     (f_h),
    .fast_lcnt     (f_l),
    .scl_in        (scl_line),
    .scl_drive_low (drv),
    .scl_rise_stb  (rise),
    .scl_fall_stb  (fall)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic start_run();
    @(posedge clk); #1 en = 1'b1;
    @(posedge clk);
  endtask

  task automatic end_run();
    @(posedge clk); #1 en = 1'b0; stretch = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  // Measures hold, first low, first high (with optional stretch), second low.
  task automatic measure(input int eh, input int el, input int ehi, input int sn);
    int n, fc, rc, rpos, stray, ff;
    stray = 0;
    n = 0;
    @(negedge clk);
    while (drv == 1'b0 && n < 1000) begin
      n++;
      if (rise || fall) stray++;
      @(negedge clk);
    end
    check_eq("R2 hold length", n, eh);
    n = 0; fc = 0; ff = fall;
    while (drv == 1'b1 && n < 1000) begin
      n++;
      if (fall) fc++;
      if (rise) stray++;
      @(negedge clk);
    end
    check_eq("R3 low length", n, el);
    check_eq("R8 fall strobe count", fc, 1);
    check_eq("R8 fall strobe first low cycle", int'(ff), 1);
    n = 0; rc = 0; rpos = -1;
    while (drv == 1'b0 && n < 1000) begin
      n++;
      if (rise) begin
        rc++;
        if (rpos < 0) rpos = n;
      end
      if (fall) stray++;
      if (n == sn && stretch) begin
        @(posedge clk); #1 stretch = 1'b0;
      end
      @(negedge clk);
    end
    check_eq("R4 R5 high length", n, ehi + sn);
    check_eq("R8 rise strobe count", rc, 1);
    check_eq("R5 rise strobe position", rpos, sn + 1);
    n = 0;
    while (drv == 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check_eq("R3 second low length", n, el);
    check_eq("R8 stray strobes", stray, 0);
  endtask

  initial begin
    int hv[4];
    int lv[4];
    int n;
    hv = '{0, 1, 4, 63};
    lv = '{0, 2, 5, 63};

    // R9: reset state
    repeat (3) @(negedge clk);
    check_eq("R9 drive low in reset", int'(drv), 0);
    check_eq("R9 strobes in reset", int'(rise) + int'(fall), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 drive low after reset", int'(drv), 0);

    // R1..R5, R8: sweep over counts, both modes, stretch lengths
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          int sn;
          sn = (i + j) % 4;
          @(posedge clk); #1;
          fast_sel = (m == 1);
          if (m == 1) begin
            f_h = CW'(hv[i]); f_l = CW'(lv[j]);
            s_h = CW'(hv[i] ^ 7); s_l = CW'(lv[j] ^ 9);
          end else begin
            s_h = CW'(hv[i]); s_l = CW'(lv[j]);
            f_h = CW'(hv[i] ^ 11); f_l = CW'(lv[j] ^ 6);
          end
          stretch = (sn > 0);
          start_run();
          // R1: lengths follow the selected pair only
          measure(hv[i] + 3, lv[j] + 1, hv[i] + 8, sn);
          end_run();
        end
      end
    end

    // R6: counts rewritten in the very cycle en rises are not used
    @(posedge clk); #1 fast_sel = 1'b0; s_h = 6'd3; s_l = 6'd2;
    @(posedge clk); #1 en = 1'b1; s_h = 6'd9;
    @(posedge clk);
    measure(6, 3, 11, 0);
    end_run();

    // R6: changes while running are ignored until the next enable
    @(posedge clk); #1 s_h = 6'd3; s_l = 6'd2; fast_sel = 1'b0;
    start_run();
    #1 s_l = 6'd10; fast_sel = 1'b1; f_h = 6'd20; f_l = 6'd20;
    measure(6, 3, 11, 0);
    end_run();
    start_run();
    measure(23, 21, 28, 0);
    end_run();

    // R7: disable mid low phase, then a fresh enable restarts the hold
    @(posedge clk); #1 fast_sel = 1'b0; s_h = 6'd2; s_l = 6'd4;
    start_run();
    n = 0;
    @(negedge clk);
    while (drv == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    @(posedge clk); #1 en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_eq("R7 released after disable", int'(drv), 0);
    check_eq("R7 strobes quiet after disable", int'(rise) + int'(fall), 0);
    repeat (3) @(negedge clk);
    check_eq("R7 stays released", int'(drv), 0);
    start_run();
    measure(5, 5, 10, 0);
    end_run();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule